// File: doc/BRIEF.md
# Extended-Precision Mantissa Extractor

This unit takes one extended-precision floating-point operand and returns its mantissa rescaled into the interval [1.0, 2.0). The operand has a sign bit, a 15-bit biased exponent and a 64-bit significand with an explicit integer bit. For a finite nonzero operand the result keeps the sign and the significand and replaces the exponent with the bias. A denormal operand is first normalised by its leading-zero count. Zeros pass through with their sign. NaNs come back quieted. An infinity becomes the default NaN.

An operand is accepted through a valid/ready handshake when the unit is idle. The result appears a fixed number of cycles later, together with an invalid-operation flag and four condition-code bits. The condition codes are derived from the result, not from the operand. The result and flags stay put until the consumer acknowledges them. Operand widths and latency are parameters. A parameter also chooses how the leading-zero counter is built.

Top module: `xm_mant_extract`

## Requirements
- R1: An operand whose exponent is all ones and whose significand bits 62..0 are not all zero is a NaN. The result keeps the sign, the exponent and the significand, except that significand bits 63 and 62 are forced to 1.
- R2: A NaN whose significand bit 62 is 0 is signalling, and out_invalid is 1 while its result is valid. A NaN with bit 62 set, and any other operand, gives out_invalid 0. out_invalid is never 1 while out_valid is 0, and it returns to 0 for the next operation.
- R3: An operand whose exponent is all ones and whose significand bits 62..0 are zero is an infinity of either sign. It yields out_sign 1, an all-ones exponent and an all-ones significand.
- R4: An operand with zero exponent and zero significand yields zero exponent and zero significand with the operand's sign.
- R5: An operand with zero exponent and a nonzero significand has its significand shifted left by its leading-zero count, so that bit 63 becomes 1. The result exponent is 0x3FFF and the sign is kept.
- R6: An operand with an exponent that is neither zero nor all ones yields the operand's sign and significand, unchanged even when bit 63 is 0, with exponent 0x3FFF.
- R7: The condition codes are computed from the result:
  - cc_neg is the result sign.
  - cc_zero is 1 when the exponent and significand are zero.
  - cc_inf is 1 when the exponent is all ones and significand bits 62..0 are zero.
  - cc_nan is 1 when the exponent is all ones and those bits are nonzero.
- R8: out_valid rises exactly LATENCY (default 31) clock edges after the edge that accepts an operand.
- R9: in_ready is 1 only while the unit is idle. An operand offered while an operation is in flight or a result is pending is not taken and does not change that result.
- R10: While out_valid is 1 and out_ready is 0, the result, out_invalid and the condition codes hold steady. The edge with out_valid and out_ready both high clears out_valid and raises in_ready.
- R11: After reset, in_ready is 1 and out_valid and out_invalid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Unit idle, operand will be taken |
| in_sign | input | 1 | Operand sign |
| in_exp | input | EXP_W | Operand biased exponent |
| in_sig | input | SIG_W | Operand significand with explicit integer bit |
| out_valid | output | 1 | Result available |
| out_ready | input | 1 | Consumer takes the result |
| out_sign | output | 1 | Result sign |
| out_exp | output | EXP_W | Result exponent |
| out_sig | output | SIG_W | Result significand |
| out_invalid | output | 1 | Invalid operation (signalling NaN operand) |
| cc_neg | output | 1 | Result is negative |
| cc_zero | output | 1 | Result is zero |
| cc_inf | output | 1 | Result is an infinity |
| cc_nan | output | 1 | Result is a NaN |

## Verification
The bench goes after the operands at the edges of the classification:
- A denormal with only bit 0 set needs the full 63-place shift. A wrong leading-zero count would leave the integer bit clear or move it off the top.
- A pseudo-denormal with bit 63 already set needs no shift at all.
- An unnormal with bit 63 clear must not be normalised.
- Infinities of both signs must become the all-ones NaN, not pass through as infinities.
- A quiet NaN next to a signalling NaN shows whether out_invalid follows bit 62 and whether it is cleared for the following operation.

Exact latency counting catches a counter that is off by one. A held result under back-pressure, and a second operand pushed in during a busy period, expose a unit that overwrites its pending result.

// File: rtl/xm_pkg.sv
package xm_pkg;

   typedef enum logic [1:0] {
      XM_IDLE = 2'd0,
      XM_RUN  = 2'd1,
      XM_DONE = 2'd2
   } xm_state_e;

   typedef struct packed {
      logic neg;
      logic zero;
      logic inf;
      logic nan;
   } xm_cc_t;

endpackage

// File: rtl/xm_lzc.sv
module xm_lzc #(
   parameter int W    = 64,
   parameter bit TREE = 1'b1,
   localparam int CW  = $clog2(W)
) (
   input  logic [W-1:0]  vec,
   output logic [CW-1:0] count
);

   if (W < 4 || (W & (W - 1)) != 0) begin : g_bad_w
      $error("xm_lzc: W must be a power of two of at least 4");
   end

   if (TREE) begin : g_tree
      localparam int HW  = W / 2;
      localparam int HCW = CW - 1;

      function automatic logic [HCW-1:0] half_lzc(input logic [HW-1:0] v);
         logic [HCW-1:0] c;
         c = '0;
         for (int i = 0; i < HW; i++) begin
            if (v[i]) c = HCW'(HW - 1 - i);
         end
         return c;
      endfunction

      logic [HW-1:0]  upper, lower;
      logic [HCW-1:0] cnt_up, cnt_lo;
      logic           up_any;

      always_comb begin
         upper  = vec[W-1:HW];
         lower  = vec[HW-1:0];
         up_any = |upper;
         cnt_up = half_lzc(upper);
         cnt_lo = half_lzc(lower);
         count  = up_any ? {1'b0, cnt_up} : {1'b1, cnt_lo};
      end
   end else begin : g_flat
      always_comb begin
         count = '0;
         for (int i = 0; i < W; i++) begin
            if (vec[i]) count = CW'(W - 1 - i);
         end
      end
   end

endmodule

// File: rtl/xm_classify.sv
module xm_classify #(
   parameter int EXP_W    = 15,
   parameter int SIG_W    = 64,
   parameter bit LZC_TREE = 1'b1,
   localparam int SH_W    = $clog2(SIG_W)
) (
   input  logic             op_sign,
   input  logic [EXP_W-1:0] op_exp,
   input  logic [SIG_W-1:0] op_sig,
   output logic             res_sign,
   output logic [EXP_W-1:0] res_exp,
   output logic [SIG_W-1:0] res_sig,
   output logic             res_snan
);

   localparam logic [EXP_W-1:0] EXP_MAX = '1;
   localparam logic [EXP_W-1:0] BIAS    = EXP_W'((1 << (EXP_W - 1)) - 1);

   logic [SH_W-1:0]  shamt;
   logic             exp_max, exp_zero, frac_nz, sig_nz;
   logic [SIG_W-1:0] norm_sig;

   xm_lzc #(.W(SIG_W), .TREE(LZC_TREE)) i_lzc (
      .vec   (op_sig),
      .count (shamt)
   );

   always_comb begin
      exp_max  = (op_exp == EXP_MAX);
      exp_zero = (op_exp == '0);
      frac_nz  = |op_sig[SIG_W-2:0];
      sig_nz   = |op_sig;
      norm_sig = sig_nz ? (op_sig << shamt) : '0;

      res_sign = op_sign;
      res_exp  = BIAS;
      res_sig  = op_sig;
      res_snan = 1'b0;

      if (exp_max) begin
         if (frac_nz) begin
            res_exp            = op_exp;
            res_sig            = op_sig;
            res_sig[SIG_W-1]   = 1'b1;
            res_sig[SIG_W-2]   = 1'b1;
            res_snan           = ~op_sig[SIG_W-2];
         end else begin
            res_sign = 1'b1;
            res_exp  = '1;
            res_sig  = '1;
         end
      end else if (exp_zero) begin
         if (!sig_nz) begin
            res_exp = '0;
            res_sig = '0;
         end else begin
            res_sig = norm_sig;
         end
      end
   end

endmodule

// File: rtl/xm_ccgen.sv
module xm_ccgen
   import xm_pkg::*;
#(
   parameter int EXP_W = 15,
   parameter int SIG_W = 64
) (
   input  logic             r_sign,
   input  logic [EXP_W-1:0] r_exp,
   input  logic [SIG_W-1:0] r_sig,
   output xm_cc_t           cc
);

   logic top_exp, low_frac_nz;

   always_comb begin
      top_exp     = &r_exp;
      low_frac_nz = |r_sig[SIG_W-2:0];
      cc.neg      = r_sign;
      cc.zero     = (r_exp == '0) && (r_sig == '0);
      cc.inf      = top_exp && !low_frac_nz;
      cc.nan      = top_exp && low_frac_nz;
   end

endmodule

// File: rtl/xm_mant_extract.sv
module xm_mant_extract
   import xm_pkg::*;
#(
   parameter int EXP_W    = 15,
   parameter int SIG_W    = 64,
   parameter int LATENCY  = 31,
   parameter bit LZC_TREE = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   output logic             in_ready,
   input  logic             in_sign,
   input  logic [EXP_W-1:0] in_exp,
   input  logic [SIG_W-1:0] in_sig,
   output logic             out_valid,
   input  logic             out_ready,
   output logic             out_sign,
   output logic [EXP_W-1:0] out_exp,
   output logic [SIG_W-1:0] out_sig,
   output logic             out_invalid,
   output logic             cc_neg,
   output logic             cc_zero,
   output logic             cc_inf,
   output logic             cc_nan
);

   localparam int CNT_W = $clog2(LATENCY + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(LATENCY - 1);

   if (LATENCY < 1) begin : g_bad_lat
      $error("xm_mant_extract: LATENCY must be at least 1");
   end
   if (EXP_W < 3 || SIG_W < 4) begin : g_bad_width
      $error("xm_mant_extract: operand widths too small");
   end

   xm_state_e        state_q;
   logic [CNT_W-1:0] cnt_q;
   logic             snan_q;
   logic             accept;

   logic             c_sign, c_snan;
   logic [EXP_W-1:0] c_exp;
   logic [SIG_W-1:0] c_sig;
   xm_cc_t           cc;

   xm_classify #(
      .EXP_W    (EXP_W),
      .SIG_W    (SIG_W),
      .LZC_TREE (LZC_TREE)
   ) i_classify (
      .op_sign  (in_sign),
      .op_exp   (in_exp),
      .op_sig   (in_sig),
      .res_sign (c_sign),
      .res_exp  (c_exp),
      .res_sig  (c_sig),
      .res_snan (c_snan)
   );

   assign in_ready = (state_q == XM_IDLE);
   assign accept   = in_valid && in_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q     <= XM_IDLE;
         cnt_q       <= '0;
         snan_q      <= 1'b0;
         out_valid   <= 1'b0;
         out_invalid <= 1'b0;
         out_sign    <= 1'b0;
         out_exp     <= '0;
         out_sig     <= '0;
      end else begin
         unique case (state_q)
            XM_IDLE: begin
               if (accept) begin
                  state_q     <= XM_RUN;
                  cnt_q       <= CNT_LOAD;
                  snan_q      <= c_snan;
                  out_invalid <= 1'b0;
                  out_sign    <= c_sign;
                  out_exp     <= c_exp;
                  out_sig     <= c_sig;
               end
            end
            XM_RUN: begin
               if (cnt_q == '0) begin
                  state_q     <= XM_DONE;
                  out_valid   <= 1'b1;
                  out_invalid <= snan_q;
               end else begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            XM_DONE: begin
               if (out_ready) begin
                  state_q     <= XM_IDLE;
                  out_valid   <= 1'b0;
                  out_invalid <= 1'b0;
               end
            end
            default: state_q <= XM_IDLE;
         endcase
      end
   end

   xm_ccgen #(.EXP_W(EXP_W), .SIG_W(SIG_W)) i_ccgen (
      .r_sign (out_sign),
      .r_exp  (out_exp),
      .r_sig  (out_sig),
      .cc     (cc)
   );

   assign cc_neg  = cc.neg;
   assign cc_zero = cc.zero;
   assign cc_inf  = cc.inf;
   assign cc_nan  = cc.nan;

endmodule

// File: rtl/xm_mant_extract_chk.sv
module xm_mant_extract_chk #(
   parameter int EXP_W   = 15,
   parameter int SIG_W   = 64,
   parameter int LATENCY = 31
) (
   input logic             clk,
   input logic             rst_n,
   input logic             in_valid,
   input logic             in_ready,
   input logic             out_valid,
   input logic             out_ready,
   input logic             out_sign,
   input logic [EXP_W-1:0] out_exp,
   input logic [SIG_W-1:0] out_sig,
   input logic             out_invalid,
   input logic             cc_zero,
   input logic             cc_inf,
   input logic             cc_nan
);

   localparam int SW = $clog2(LATENCY + 2) + 1;
   localparam logic [EXP_W-1:0] BIAS = EXP_W'((1 << (EXP_W - 1)) - 1);

   logic [SW-1:0] since_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) since_q <= '1;
      else if (in_valid && in_ready) since_q <= '0;
      else if (since_q != '1) since_q <= since_q + 1'b1;
   end

   // R8
   a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid) |-> since_q == SW'(LATENCY));

   // R9
   a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
      in_ready |-> !out_valid);

   // R10
   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_sig) && $stable(out_exp)
         && $stable(out_sign) && $stable(out_invalid));

   // R10
   a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && out_ready |=> !out_valid && in_ready);

   // R2
   a_r2_inv_with_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_invalid |-> out_valid && cc_nan);

   // R1
   a_r1_nan_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && cc_nan |-> out_sig[SIG_W-1] && out_sig[SIG_W-2]);

   // R3
   a_r3_never_inf: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> !cc_inf);

   // R6
   a_r6_scaled_exp: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !cc_nan && !cc_zero |-> out_exp == BIAS);

endmodule

bind xm_mant_extract xm_mant_extract_chk #(
   .EXP_W   (EXP_W),
   .SIG_W   (SIG_W),
   .LATENCY (LATENCY)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .in_valid    (in_valid),
   .in_ready    (in_ready),
   .out_valid   (out_valid),
   .out_ready   (out_ready),
   .out_sign    (out_sign),
   .out_exp     (out_exp),
   .out_sig     (out_sig),
   .out_invalid (out_invalid),
   .cc_zero     (cc_zero),
   .cc_inf      (cc_inf),
   .cc_nan      (cc_nan)
);

// File: tb/test_xm_mant_extract.sv
module test_xm_mant_extract;

   localparam int EW  = 15;
   localparam int SW  = 64;
   localparam int LAT = 31;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          in_valid = 1'b0, in_ready;
   logic          in_sign = 1'b0;
   logic [EW-1:0] in_exp = '0;
   logic [SW-1:0] in_sig = '0;
   logic          out_valid, out_ready = 1'b0;
   logic          out_sign, out_invalid, cc_neg, cc_zero, cc_inf, cc_nan;
   logic [EW-1:0] out_exp;
   logic [SW-1:0] out_sig;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   xm_mant_extract #(.EXP_W(EW), .SIG_W(SW), .LATENCY(LAT)) i_xm_mant_extract (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
      .in_sign(in_sign), .in_exp(in_exp), .in_sig(in_sig),
      .out_valid(out_valid), .out_ready(out_ready),
      .out_sign(out_sign), .out_exp(out_exp), .out_sig(out_sig),
      .out_invalid(out_invalid), .cc_neg(cc_neg), .cc_zero(cc_zero),
      .cc_inf(cc_inf), .cc_nan(cc_nan)
   );

   task automatic check(input string req, input logic [127:0] got, input logic [127:0] exp);
      checks++;
      if (got !== exp) begin
         failures++;
         $display("FAIL %s got=%h expected=%h", req, got, exp);
      end
   endtask

   // expected result from the requirements
   function automatic logic [80:0] model(input logic s, input logic [EW-1:0] e, input logic [SW-1:0] m);
      logic [SW-1:0] t;
      if (e == '1) begin
         if (m[SW-2:0] != '0) return {~m[SW-2], s, e, 2'b11, m[SW-3:0]};
         return {1'b0, 1'b1, {EW{1'b1}}, {SW{1'b1}}};
      end
      if (e == '0) begin
         if (m == '0) return {1'b0, s, {EW{1'b0}}, {SW{1'b0}}};
         t = m;
         while (!t[SW-1]) t = t << 1;
         return {1'b0, s, 15'h3FFF, t};
      end
      return {1'b0, s, 15'h3FFF, m};
   endfunction

   function automatic logic [3:0] cc_model(input logic [79:0] r);
      logic ez, em, fz;
      ez = (r[78:64] == '0);
      em = (r[78:64] == '1);
      fz = (r[62:0] == '0);
      return {r[79], ez && r[63:0] == '0, em && fz, em && !fz};
   endfunction

   task automatic start_op(input logic s, input logic [EW-1:0] e, input logic [SW-1:0] m);
      @(negedge clk);
      in_sign = s; in_exp = e; in_sig = m; in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic wait_valid(output int lat);
      lat = 0;
      while (!out_valid && lat < 200) begin
         @(negedge clk);
         lat++;
      end
   endtask

   task automatic ack();
      out_ready = 1'b1;
      @(negedge clk);
      out_ready = 1'b0;
   endtask

   task automatic run_check(input string req, input logic s, input logic [EW-1:0] e, input logic [SW-1:0] m);
      int lat;
      logic [80:0] x;
      start_op(s, e, m);
      wait_valid(lat);
      x = model(s, e, m);
      check({req, " result"}, {out_sign, out_exp, out_sig}, x[79:0]);
      check("R2 invalid flag", out_invalid, x[80]);
      check("R7 condition codes", {cc_neg, cc_zero, cc_inf, cc_nan}, cc_model(x[79:0]));
      ack();
   endtask

   task automatic t_reset();
      check("R11 in_ready after reset", in_ready, 1'b1);
      check("R11 out_valid after reset", out_valid, 1'b0);
      check("R11 out_invalid after reset", out_invalid, 1'b0);
   endtask

   task automatic t_normals();
      run_check("R6 positive normal", 1'b0, 15'h4005, 64'hC90F_DAA2_2168_C235);
      run_check("R6 negative normal", 1'b1, 15'h0001, 64'h8000_0000_0000_0001);
      run_check("R6 unnormal kept", 1'b0, 15'h2222, 64'h1234_5678_9ABC_DEF0);
   endtask

   task automatic t_zero();
      run_check("R4 positive zero", 1'b0, 15'h0, 64'h0);
      run_check("R4 negative zero", 1'b1, 15'h0, 64'h0);
   endtask

   task automatic t_denormal();
      run_check("R5 denormal lsb", 1'b0, 15'h0, 64'h1);
      run_check("R5 denormal mid", 1'b1, 15'h0, 64'h0000_0000_0012_3400);
      run_check("R5 pseudo denormal", 1'b0, 15'h0, 64'h8000_0000_0000_0007);
      run_check("R5 denormal upper half", 1'b0, 15'h0, 64'h0000_8000_0000_0000);
   endtask

   task automatic t_special();
      run_check("R3 positive infinity", 1'b0, 15'h7FFF, 64'h8000_0000_0000_0000);
      run_check("R3 negative infinity", 1'b1, 15'h7FFF, 64'h0);
      run_check("R1 quiet nan", 1'b1, 15'h7FFF, 64'hC000_0000_0000_1234);
      run_check("R1 signalling nan", 1'b0, 15'h7FFF, 64'h8000_0000_0000_0055);
      run_check("R2 flag cleared after snan", 1'b0, 15'h3000, 64'h8000_0000_0000_0000);
   endtask

   task automatic t_latency();
      int lat;
      start_op(1'b0, 15'h3FFF, 64'h8000_0000_0000_0000);
      wait_valid(lat);
      check("R8 latency", lat, LAT);
      ack();
   endtask

   task automatic t_busy_and_hold();
      int lat;
      logic [79:0] first;
      logic [80:0] x;
      start_op(1'b1, 15'h1234, 64'hF000_0000_0000_000F);
      x = model(1'b1, 15'h1234, 64'hF000_0000_0000_000F);
      first = x[79:0];
      in_sign = 1'b0; in_exp = 15'h0; in_sig = 64'h0; in_valid = 1'b1;
      @(negedge clk);
      check("R9 in_ready low while busy", in_ready, 1'b0);
      repeat (3) @(negedge clk);
      in_valid = 1'b0;
      wait_valid(lat);
      check("R9 busy offer ignored", {out_sign, out_exp, out_sig}, first);
      repeat (6) @(negedge clk);
      check("R10 held valid", {out_valid, in_ready}, 2'b10);
      check("R10 held result", {out_sign, out_exp, out_sig}, first);
      check("R10 held flags", {out_invalid, cc_neg, cc_zero, cc_inf, cc_nan}, 5'b01000);
      ack();
      check("R10 released", {out_valid, in_ready}, 2'b01);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_normals();
      t_zero();
      t_denormal();
      t_special();
      t_latency();
      t_busy_and_hold();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++;
            failures++;
            $display("FAIL watchdog expired");
         end
      join_any
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule